// File: doc/BRIEF.md
# Accumulator Decimal Adjust and Rotate Unit

This block takes an 8-bit accumulator value and produces the final accumulator and status flags for four operations. The first is decimal correction after a binary add of two packed BCD bytes. The second compares the accumulator with an immediate byte. The last two are circular rotates, one left and one right. The caller presents the operands, an operation code and the current flags together with `valid_i`. One clock later the block returns the new accumulator and the full flag set, marked by `valid_o`.

The flag inputs carry the present sign, zero, auxiliary-carry, parity and carry values. The block needs all of them because a rotate must return the untouched flags unchanged. The outputs are registered, and they hold their last value in any cycle where no request is made.

Top module: `acc_adjust_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `acc_o` and every flag output are 0.
- R2: A request with `valid_i`=1 shows up one clock later with `valid_o`=1. With `valid_i`=0, `valid_o` drops to 0 on the next clock and the accumulator and flag outputs keep their values.
- R3: Decimal adjust (`op_i`=2'b00) adds 6 to the low nibble when that nibble is above 9 or `ac_i`=1. `ac_o` is the carry out of bit 3 produced by that correction, and is 0 when no correction is made.
- R4: Decimal adjust then examines the high nibble of the partly corrected value. If that nibble is above 9 or `cy_i`=1, it adds 0x60. `cy_o` is 1 if `cy_i` was 1 or if either correction carried out of bit 7.
- R5: Decimal adjust sets `s_o` to bit 7 of the result and `z_o` when the result is zero. It sets `p_o` when the result has an even number of one bits.
- R6: Compare (`op_i`=2'b01) returns `acc_i` unchanged and takes its flags from `acc_i - imm_i`. `cy_o` is set when `imm_i > acc_i` (unsigned), `z_o` when the two are equal, and `s_o` from bit 7 of the difference. `ac_o` is set on a borrow from the low nibble, and `p_o` is even parity of the difference.
- R7: Rotate left (`op_i`=2'b10) produces `{acc_i[6:0], acc_i[7]}` and sets `cy_o` = `acc_i[7]`.
- R8: Rotate right (`op_i`=2'b11) produces `{acc_i[0], acc_i[7:1]}` and sets `cy_o` = `acc_i[0]`.
- R9: Both rotates pass `s_i`, `z_i`, `ac_i` and `p_i` to the outputs unchanged, and they ignore `imm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 00 adjust, 01 compare, 10 rotate left, 11 rotate right |
| acc_i | input | 8 | Accumulator operand |
| imm_i | input | 8 | Immediate byte for compare |
| s_i | input | 1 | Current sign flag |
| z_i | input | 1 | Current zero flag |
| ac_i | input | 1 | Current auxiliary-carry flag |
| p_i | input | 1 | Current parity flag |
| cy_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result strobe |
| acc_o | output | 8 | New accumulator |
| s_o | output | 1 | Sign flag |
| z_o | output | 1 | Zero flag |
| ac_o | output | 1 | Auxiliary-carry flag |
| p_o | output | 1 | Parity flag |
| cy_o | output | 1 | Carry flag |

## Verification
The assertions assume that every input stays settled across each rising clock edge. They also assume `valid_i` is low throughout reset, so that the first cycle after reset does not relate outputs to a request that was never made. The bench changes inputs only on falling edges and holds `valid_i` at 0 until reset has been released. Random operands, operation codes and flag inputs are mixed with idle cycles that carry random data, and every reachable flag combination falls within those assumptions.

// File: rtl/acc_adj_pkg.sv
package acc_adj_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;

  typedef enum logic [1:0] {
    OP_DADJ = 2'b00,
    OP_CMP  = 2'b01,
    OP_ROL  = 2'b10,
    OP_ROR  = 2'b11
  } op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic even_par(input logic [DATA_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/dadj_core.sv
module dadj_core
  import acc_adj_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] acc_i,
  input  logic         ac_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         ac_o,
  output logic         cy_o
);
  localparam int unsigned NW = W / 2;
  localparam logic [W:0]    LO_ADD = {{(W-3){1'b0}}, 4'b0110};
  localparam logic [W:0]    HI_ADD = LO_ADD << NW;
  localparam logic [NW-1:0] NINE   = NW'(9);

  logic          lo_fix, hi_fix;
  logic [NW:0]   lo_sum;
  logic [W:0]    step1, step2;

  always_comb begin
    lo_fix = (acc_i[NW-1:0] > NINE) | ac_i;
    lo_sum = {1'b0, acc_i[NW-1:0]} + (NW+1)'(6);
    step1  = {1'b0, acc_i} + (lo_fix ? LO_ADD : '0);
    // high test sees the value after the low correction
    hi_fix = (step1[W-1:NW] > NINE) | cy_i;
    step2  = {1'b0, step1[W-1:0]} + (hi_fix ? HI_ADD : '0);
    res_o  = step2[W-1:0];
    ac_o   = lo_fix & lo_sum[NW];
    cy_o   = cy_i | step1[W] | step2[W];
  end
endmodule

// File: rtl/cmp_core.sv
module cmp_core
  import acc_adj_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o,
  output logic         nib_borrow_o
);
  localparam int unsigned NW = W / 2;

  logic [W:0]  full_d;
  logic [NW:0] low_d;

  always_comb begin
    full_d       = {1'b0, acc_i} - {1'b0, imm_i};
    low_d        = {1'b0, acc_i[NW-1:0]} - {1'b0, imm_i[NW-1:0]};
    diff_o       = full_d[W-1:0];
    borrow_o     = full_d[W];
    nib_borrow_o = low_d[NW];
  end
endmodule

// File: rtl/rot_core.sv
module rot_core
  import acc_adj_pkg::*;
#(
  parameter int unsigned W    = DATA_W,
  parameter bit          LEFT = 1'b1
) (
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  generate
    if (LEFT) begin : g_left
      assign res_o = {acc_i[W-2:0], acc_i[W-1]};
      assign cy_o  = acc_i[W-1];
    end else begin : g_right
      assign res_o = {acc_i[0], acc_i[W-1:1]};
      assign cy_o  = acc_i[0];
    end
  endgenerate
endmodule

// File: rtl/acc_adjust_unit.sv
module acc_adjust_unit
  import acc_adj_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              s_i,
  input  logic              z_i,
  input  logic              ac_i,
  input  logic              p_i,
  input  logic              cy_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              s_o,
  output logic              z_o,
  output logic              ac_o,
  output logic              p_o,
  output logic              cy_o
);
  localparam int unsigned N_ROT = 2;

  logic [DATA_W-1:0] da_res, cmp_diff;
  logic              da_ac, da_cy, cmp_cy, cmp_ac;
  logic [DATA_W-1:0] rot_res [N_ROT];
  logic              rot_cy  [N_ROT];

  logic [DATA_W-1:0] acc_d, acc_q;
  flags_t            fl_d, fl_q, fl_in;
  logic              vld_q;

  dadj_core #(.W(DATA_W)) i_dadj (
    .acc_i (acc_i),
    .ac_i  (ac_i),
    .cy_i  (cy_i),
    .res_o (da_res),
    .ac_o  (da_ac),
    .cy_o  (da_cy)
  );

  cmp_core #(.W(DATA_W)) i_cmp (
    .acc_i        (acc_i),
    .imm_i        (imm_i),
    .diff_o       (cmp_diff),
    .borrow_o     (cmp_cy),
    .nib_borrow_o (cmp_ac)
  );

  // index 0 rotates left, index 1 rotates right
  for (genvar g = 0; g < N_ROT; g++) begin : g_rot
    rot_core #(.W(DATA_W), .LEFT(g == 0)) i_rot (
      .acc_i (acc_i),
      .res_o (rot_res[g]),
      .cy_o  (rot_cy[g])
    );
  end

  assign fl_in = '{s: s_i, z: z_i, ac: ac_i, p: p_i, cy: cy_i};

  always_comb begin
    acc_d = acc_i;
    fl_d  = fl_in;
    unique case (op_e'(op_i))
      OP_DADJ: begin
        acc_d = da_res;
        fl_d  = '{s: da_res[DATA_W-1], z: (da_res == '0), ac: da_ac,
                  p: even_par(da_res), cy: da_cy};
      end
      OP_CMP: begin
        acc_d = acc_i;
        fl_d  = '{s: cmp_diff[DATA_W-1], z: (cmp_diff == '0), ac: cmp_ac,
                  p: even_par(cmp_diff), cy: cmp_cy};
      end
      OP_ROL: begin
        acc_d   = rot_res[0];
        fl_d.cy = rot_cy[0];
      end
      OP_ROR: begin
        acc_d   = rot_res[1];
        fl_d.cy = rot_cy[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= '0;
      fl_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        acc_q <= acc_d;
        fl_q  <= fl_d;
      end
    end
  end

  assign valid_o = vld_q;
  assign acc_o   = acc_q;
  assign s_o     = fl_q.s;
  assign z_o     = fl_q.z;
  assign ac_o    = fl_q.ac;
  assign p_o     = fl_q.p;
  assign cy_o    = fl_q.cy;
endmodule

// File: rtl/acc_adjust_unit_chk.sv
module acc_adjust_unit_chk
  import acc_adj_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [DATA_W-1:0] imm_i,
  input logic              s_i,
  input logic              z_i,
  input logic              ac_i,
  input logic              p_i,
  input logic              cy_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              s_o,
  input logic              z_o,
  input logic              ac_o,
  input logic              p_o,
  input logic              cy_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!valid_o && acc_o == '0 && !cy_o && !z_o); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(acc_o) && $stable(cy_o) && $stable(z_o)); // R2

  AST_DADJ_CY_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_DADJ && cy_i) |=> cy_o); // R4

  AST_DADJ_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_DADJ) |=> (p_o == ~(^acc_o)) && (s_o == acc_o[DATA_W-1])); // R5

  AST_CMP_ACC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_CMP) |=> acc_o == $past(acc_i)); // R6

  AST_ROL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ROL) |=> cy_o == $past(acc_i[DATA_W-1]) && acc_o[0] == cy_o); // R7

  AST_ROR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_ROR) |=> cy_o == $past(acc_i[0]) && acc_o[DATA_W-1] == cy_o); // R8

  AST_ROT_FLAGS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[1]) |=> s_o == $past(s_i) && z_o == $past(z_i)
                             && ac_o == $past(ac_i) && p_o == $past(p_i)); // R9
endmodule

bind acc_adjust_unit acc_adjust_unit_chk i_acc_adjust_unit_chk (.*);

// File: tb/test_acc_adjust_unit.sv
module test_acc_adjust_unit;
  localparam time CLK_P = 4ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] acc_i = 8'h00, imm_i = 8'h00;
  logic       s_i = 0, z_i = 0, ac_i = 0, p_i = 0, cy_i = 0;
  logic       valid_o;
  logic [7:0] acc_o;
  logic       s_o, z_o, ac_o, p_o, cy_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  acc_adjust_unit i_acc_adjust_unit (.*);

  // expected {acc, s, z, ac, p, cy}
  function automatic logic [12:0] model(input logic [1:0] op, input logic [7:0] a,
      input logic [7:0] im, input logic s, input logic z, input logic ac,
      input logic p, input logic cy);
    logic [8:0] t;
    logic [7:0] r;
    logic       nac, ncy, adj_lo, adj_hi;
    case (op)
      2'b00: begin
        adj_lo = (a[3:0] > 4'd9) || ac;
        nac    = adj_lo && (a[3:0] >= 4'd10);
        t      = {1'b0, a} + (adj_lo ? 9'd6 : 9'd0);
        ncy    = cy || t[8];
        adj_hi = (t[7:4] > 4'd9) || cy;
        t      = {1'b0, t[7:0]} + (adj_hi ? 9'h060 : 9'd0);
        ncy    = ncy || t[8];
        r      = t[7:0];
        return {r, r[7], r == 8'h00, nac, ~(^r), ncy};
      end
      2'b01: begin
        r = a - im;
        return {a, r[7], a == im, im[3:0] > a[3:0], ~(^r), im > a};
      end
      2'b10: return {a[6:0], a[7], s, z, ac, p, a[7]};
      default: return {a[0], a[7:1], s, z, ac, p, a[0]};
    endcase
  endfunction

  task automatic check(input string req, input logic [12:0] exp_v);
    logic [12:0] got;
    got = {acc_o, s_o, z_o, ac_o, p_o, cy_o};
    n_chk++;
    if (got !== exp_v || valid_o !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: got acc=%h flags(s z ac p cy)=%b valid=%b, expected acc=%h flags=%b valid=1",
               req, got[12:5], got[4:0], valid_o, exp_v[12:5], exp_v[4:0]);
    end
  endtask

  function automatic string tag(input logic [1:0] op, input logic [7:0] a, input logic ac, input logic cy);
    case (op)
      2'b00:   return (a[3:0] > 4'd9 || ac) ? "R3" : ((a > 8'h99 || cy) ? "R4" : "R5");
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] im,
                        input logic [4:0] fl);
    logic [12:0] e;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; acc_i = a; imm_i = im;
    {s_i, z_i, ac_i, p_i, cy_i} = fl;
    e = model(op, a, im, fl[4], fl[3], fl[2], fl[1], fl[0]);
    @(negedge clk_i);
    valid_i = 1'b0;
    check(tag(op, a, fl[2], fl[0]), e);
  endtask

  task automatic idle_check();
    logic [12:0] held;
    held = {acc_o, s_o, z_o, ac_o, p_o, cy_o};
    valid_i = 1'b0; op_i = 2'($urandom); acc_i = 8'($urandom); imm_i = 8'($urandom);
    {s_i, z_i, ac_i, p_i, cy_i} = 5'($urandom);
    @(negedge clk_i);
    n_chk++;
    if ({acc_o, s_o, z_o, ac_o, p_o, cy_o} !== held || valid_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: got %h valid=%b, expected %h valid=0",
               {acc_o, s_o, z_o, ac_o, p_o, cy_o}, valid_o, held);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    #(CLK_P * 3);
    n_chk++;
    if (valid_o !== 1'b0 || acc_o !== 8'h00 || {s_o, z_o, ac_o, p_o, cy_o} !== 5'b0) begin
      n_bad++;
      $display("FAIL R1: got valid=%b acc=%h flags=%b, expected 0 00 00000",
               valid_o, acc_o, {s_o, z_o, ac_o, p_o, cy_o});
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    run_op(2'b00, 8'h9A, 8'h00, 5'b00000); // R3 R4: both corrections, result 00, carry set
    run_op(2'b00, 8'h15, 8'h00, 5'b00100); // R3: aux carry forces low fix
    run_op(2'b00, 8'h29, 8'h00, 5'b00001); // R4: carry forces high fix
    run_op(2'b00, 8'h99, 8'h00, 5'b00000); // R5: no correction
    run_op(2'b00, 8'hFA, 8'h00, 5'b00000); // R4: low fix overflows bit 7
    run_op(2'b01, 8'h42, 8'h42, 5'b00000); // R6: equal
    run_op(2'b01, 8'h10, 8'h11, 5'b00000); // R6: imm above acc
    run_op(2'b01, 8'h80, 8'h01, 5'b11111); // R6: flags replaced
    run_op(2'b10, 8'h80, 8'hFF, 5'b10110); // R7 R9
    run_op(2'b11, 8'h01, 8'h00, 5'b01001); // R8 R9
    idle_check();

    for (int i = 0; i < 400; i++) begin
      run_op(2'($urandom), 8'($urandom), 8'($urandom), 5'($urandom));
      if (($urandom % 5) == 0) idle_check();
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule